// File: doc/BRIEF.md
# I2C/SMBus Interrupt Flag Controller

This block sits beside an I2C/SMBus controller core and turns the core's event signals into sticky status flags, a summary interrupt flag and one registered interrupt output. The bus state machine, the shift register and the timeout counters stay inside the core. The core supplies a live byte-transfer-complete level and single-cycle pulses for five events: addressed-as-slave, arbitration lost, SCL-low timeout, SCL-high/SDA-low timeout and wakeup from stop.

Software reaches the block through two register-style write ports and two read-back buses. The first is a control word of four enable bits: master enable, global interrupt enable, the SCL-high/SDA-low timeout interrupt enable and the wakeup enable. The second is a status word. Every sticky bit in it is cleared by writing 1 to that bit, and writing 0 leaves it alone. The SCL-low timeout keeps a flag of its own, and it also drives the interrupt, so software can clear the summary flag and the timeout flag one at a time.

Top module: `i2c_irq_flags`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `ctrl_q`, `stat_q` and `irq_o` all zero.
- R2: With master enable set, each of these sets the summary flag (`stat_q[5]`) at the clock edge where it is seen: a rising edge of `xfer_done`, an `ev_addr_match` pulse, an `ev_arb_lost` pulse and an `ev_scl_low_to` pulse. Each pulse also sets its own sticky bit: addressed `stat_q[1]`, arbitration lost `stat_q[2]`, SCL-low timeout `stat_q[3]`.
- R3: `irq_o` is registered. One cycle after the flags update it equals global enable (`ctrl_q[1]`) AND (summary flag OR SCL-low timeout flag).
- R4: A `stat_we` cycle clears each of `stat_q[5:1]` whose `stat_wdata` bit is 1. A 0 bit leaves its flag unchanged. `stat_q[0]` is read-only.
- R5: Clearing the summary flag leaves the SCL-low timeout flag, and with it `irq_o`, set until bit 3 is cleared as well.
- R6: An `ev_sda_low_to` pulse always sets `stat_q[4]`. It sets the summary flag only when `ctrl_q[2]` (timeout interrupt enable) is 1.
- R7: An `ev_wake` pulse sets the addressed bit `stat_q[1]` and the summary flag only when `ctrl_q[3]` (wakeup enable) is 1. Otherwise it has no effect.
- R8: `stat_q[0]` is a one-cycle registered copy of the live `xfer_done` level, and it follows the level whatever the enables are.
- R9: When an event pulse and a write-1 clear of the same flag fall in one cycle, the flag ends up set.
- R10: With master enable `ctrl_q[0]` at 0, no event sets any sticky flag.
- R11: A `ctrl_we` cycle loads `ctrl_wdata` into `ctrl_q` at the next edge. The bits are: 0 master enable, 1 global interrupt enable, 2 timeout interrupt enable, 3 wakeup enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_done | input | 1 | Live byte-transfer-complete level from the core |
| ev_addr_match | input | 1 | Calling-address match pulse |
| ev_arb_lost | input | 1 | Arbitration-lost pulse |
| ev_scl_low_to | input | 1 | SCL-low timeout pulse |
| ev_sda_low_to | input | 1 | SCL-high/SDA-low timeout pulse |
| ev_wake | input | 1 | Wakeup-from-stop pulse |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 4 | Control word write data |
| stat_we | input | 1 | Status write strobe (write-1-to-clear) |
| stat_wdata | input | 6 | Status write data, one clear bit per flag |
| ctrl_q | output | 4 | Control word read-back |
| stat_q | output | 6 | Status word read-back |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check the rules that hold on every cycle. They cover the reset state, `irq_o` being gated by the previous cycle's global enable and following the flags one cycle later, the write-1-to-clear rules, an event winning over a same-cycle clear, and flags staying low while master enable is off. The bench scenarios are needed for the remaining behaviour. They show which event sets which bits under each combination of the two local enables, the wakeup event reporting through the addressed bit, the live transfer-complete copy, and clearing the summary and timeout flags in sequence.

// File: rtl/i2cirq_pkg.sv
package i2cirq_pkg;
  localparam int CTRL_W = 4;
  localparam int STAT_W = 6;
  localparam int NUM_STICKY = STAT_W - 1;

  // control bit positions
  localparam int C_MEN  = 0;
  localparam int C_IE   = 1;
  localparam int C_HTOE = 2;
  localparam int C_WKE  = 3;

  // status bit positions
  localparam int S_XFER = 0;
  localparam int S_ADDR = 1;
  localparam int S_ARB  = 2;
  localparam int S_SLT  = 3;
  localparam int S_SHT  = 4;
  localparam int S_SUM  = 5;

  typedef struct packed {
    logic wk_en;
    logic hto_en;
    logic irq_en;
    logic master_en;
  } ctrl_t;

  typedef struct packed {
    logic addr;
    logic arb;
    logic scl_low;
    logic sda_low;
    logic wake;
  } evt_t;
endpackage

// File: rtl/i2cirq_ctrl_reg.sv
module i2cirq_ctrl_reg
  import i2cirq_pkg::*;
#(
  parameter int WIDTH = CTRL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/i2cirq_xfer_track.sv
module i2cirq_xfer_track (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic live_q,
  output logic rise
);
  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= level;
  end
  assign rise = level & ~live_q;
endmodule

// File: rtl/i2cirq_event_qual.sv
module i2cirq_event_qual
  import i2cirq_pkg::*;
#(
  parameter int NFLAG = NUM_STICKY
) (
  input  ctrl_t            ctrl,
  input  logic             xfer_rise,
  input  evt_t             ev,
  output logic [NFLAG-1:0] set_vec
);
  // set_vec index i maps to status bit i+1
  localparam int IX_ADDR = S_ADDR - 1;
  localparam int IX_ARB  = S_ARB - 1;
  localparam int IX_SLT  = S_SLT - 1;
  localparam int IX_SHT  = S_SHT - 1;
  localparam int IX_SUM  = S_SUM - 1;

  logic wake_ok, sht_ok, any_sum;

  always_comb begin
    wake_ok = ev.wake & ctrl.wk_en;
    sht_ok  = ev.sda_low & ctrl.hto_en;
    any_sum = xfer_rise | ev.addr | ev.arb | ev.scl_low | sht_ok | wake_ok;
    set_vec = '0;
    set_vec[IX_ADDR] = ctrl.master_en & (ev.addr | wake_ok);
    set_vec[IX_ARB]  = ctrl.master_en & ev.arb;
    set_vec[IX_SLT]  = ctrl.master_en & ev.scl_low;
    set_vec[IX_SHT]  = ctrl.master_en & ev.sda_low;
    set_vec[IX_SUM]  = ctrl.master_en & any_sum;
  end
endmodule

// File: rtl/i2cirq_sticky_flag.sv
module i2cirq_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  // an arriving event outranks a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags
  import i2cirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_done,
  input  logic              ev_addr_match,
  input  logic              ev_arb_lost,
  input  logic              ev_scl_low_to,
  input  logic              ev_sda_low_to,
  input  logic              ev_wake,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              stat_we,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq_o
);
  ctrl_t                 ctrl;
  evt_t                  ev;
  logic                  xfer_live, xfer_rise;
  logic [NUM_STICKY-1:0] set_vec, clr_vec, flag_q;
  logic                  unused_ro_bit;

  assign unused_ro_bit = stat_wdata[S_XFER];

  i2cirq_ctrl_reg #(.WIDTH(CTRL_W)) u_ctrl (
    .clk(clk), .rst(rst), .we(ctrl_we), .wdata(ctrl_wdata), .q(ctrl_q)
  );
  assign ctrl = ctrl_t'(ctrl_q);

  i2cirq_xfer_track u_xfer (
    .clk(clk), .rst(rst), .level(xfer_done), .live_q(xfer_live), .rise(xfer_rise)
  );

  assign ev = '{addr: ev_addr_match, arb: ev_arb_lost, scl_low: ev_scl_low_to,
                sda_low: ev_sda_low_to, wake: ev_wake};

  i2cirq_event_qual #(.NFLAG(NUM_STICKY)) u_qual (
    .ctrl(ctrl), .xfer_rise(xfer_rise), .ev(ev), .set_vec(set_vec)
  );

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_flag
    assign clr_vec[i] = stat_we & stat_wdata[i+1];
    i2cirq_sticky_flag u_flag (
      .clk(clk), .rst(rst), .set(set_vec[i]), .clr(clr_vec[i]), .q(flag_q[i])
    );
  end

  assign stat_q = {flag_q, xfer_live};

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= ctrl.irq_en & (flag_q[S_SUM-1] | flag_q[S_SLT-1]);
  end
endmodule

// File: rtl/i2cirq_chk.sv
module i2cirq_chk
  import i2cirq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ev_arb_lost,
  input logic              stat_we,
  input logic [STAT_W-1:0] stat_wdata,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [STAT_W-1:0] stat_q,
  input logic              irq_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ctrl_q == '0 && stat_q == '0 && !irq_o));

  assert_irq_gated_R3: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ctrl_q[C_IE]));

  assert_irq_follows_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[C_IE] && (stat_q[S_SUM] || stat_q[S_SLT])) |=> irq_o);

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (stat_we && stat_wdata[S_ARB] && !ev_arb_lost) |=> !stat_q[S_ARB]);

  assert_zero_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (stat_q[S_SUM] && !(stat_we && stat_wdata[S_SUM])) |=> stat_q[S_SUM]);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (ev_arb_lost && ctrl_q[C_MEN]) |=> stat_q[S_ARB]);

  assert_master_off_R10: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[C_MEN] && !stat_q[S_ARB]) |=> !stat_q[S_ARB]);
endmodule

bind i2c_irq_flags i2cirq_chk u_chk (
  .clk(clk), .rst(rst), .ev_arb_lost(ev_arb_lost), .stat_we(stat_we),
  .stat_wdata(stat_wdata), .ctrl_q(ctrl_q), .stat_q(stat_q), .irq_o(irq_o)
);

// File: tb/tb_i2c_irq_flags.sv
module tb_i2c_irq_flags;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // entry: {ctrl[3:0], ev[5:0] = xfer,addr,arb,slt,sht,wake, exp_stat[5:0], exp_irq}
  localparam logic [16:0] VEC [0:NVEC-1] = '{
    {4'b0011, 6'b100000, 6'b100001, 1'b1},  // xfer rise, irq on
    {4'b0001, 6'b100000, 6'b100001, 1'b0},  // global enable off
    {4'b0000, 6'b001000, 6'b000000, 1'b0},  // master off
    {4'b0011, 6'b001000, 6'b100100, 1'b1},  // arb lost
    {4'b0011, 6'b010000, 6'b100010, 1'b1},  // address match
    {4'b0011, 6'b000100, 6'b101000, 1'b1},  // scl low timeout
    {4'b0011, 6'b000010, 6'b010000, 1'b0},  // sda low timeout, local off
    {4'b0111, 6'b000010, 6'b110000, 1'b1},  // sda low timeout, local on
    {4'b0011, 6'b000001, 6'b000000, 1'b0},  // wake, local off
    {4'b1011, 6'b000001, 6'b100010, 1'b1},  // wake, local on
    {4'b0010, 6'b100000, 6'b000001, 1'b0}   // master off, live copy only
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xfer_done = 1'b0;
  logic       ev_addr_match = 1'b0, ev_arb_lost = 1'b0, ev_scl_low_to = 1'b0;
  logic       ev_sda_low_to = 1'b0, ev_wake = 1'b0;
  logic       ctrl_we = 1'b0, stat_we = 1'b0;
  logic [3:0] ctrl_wdata = '0;
  logic [5:0] stat_wdata = '0;
  logic [3:0] ctrl_q;
  logic [5:0] stat_q;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_flags dut (
    .clk(clk), .rst(rst), .xfer_done(xfer_done), .ev_addr_match(ev_addr_match),
    .ev_arb_lost(ev_arb_lost), .ev_scl_low_to(ev_scl_low_to),
    .ev_sda_low_to(ev_sda_low_to), .ev_wake(ev_wake), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_pulses(input logic [4:0] p);
    {ev_addr_match, ev_arb_lost, ev_scl_low_to, ev_sda_low_to, ev_wake} = p;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; xfer_done = 1'b0; set_pulses(5'b0); ctrl_we = 1'b0; stat_we = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_ctrl(input logic [3:0] d);
    ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic write_stat(input logic [5:0] d);
    stat_we = 1'b1; stat_wdata = d;
    @(negedge clk);
    stat_we = 1'b0; stat_wdata = '0;
  endtask

  task automatic pulse(input logic [4:0] p);
    set_pulses(p);
    @(negedge clk);
    set_pulses(5'b0);
  endtask

  initial begin
    // R1: reset state
    nclk(2);
    chk("R1 ctrl after reset", {4'b0, ctrl_q}, 8'h00);
    chk("R1 stat after reset", {2'b0, stat_q}, 8'h00);
    chk("R1 irq after reset", {7'b0, irq_o}, 8'h00);

    // table walk: R2 R3 R6 R7 R8 R10
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      write_ctrl(VEC[v][16:13]);
      xfer_done = VEC[v][12];
      set_pulses(VEC[v][11:7]);
      @(negedge clk);
      set_pulses(5'b0);
      @(negedge clk);
      chk($sformatf("R2/R6/R7/R8/R10 vector %0d stat", v), {2'b0, stat_q}, {2'b0, VEC[v][6:1]});
      chk($sformatf("R3 vector %0d irq", v), {7'b0, irq_o}, {7'b0, VEC[v][0]});
    end

    // R11: control read-back
    do_reset();
    write_ctrl(4'b1010);
    chk("R11 ctrl readback", {4'b0, ctrl_q}, 8'h0A);

    // R5: summary and scl-low timeout cleared separately
    do_reset();
    write_ctrl(4'b0011);
    pulse(5'b00100);
    nclk(1);
    chk("R5 irq after slt", {7'b0, irq_o}, 8'h01);
    write_stat(6'b100000);
    chk("R5 slt kept after summary clear", {2'b0, stat_q}, 8'b0000_1000);
    nclk(1);
    chk("R5 irq held by slt", {7'b0, irq_o}, 8'h01);
    write_stat(6'b001000);
    nclk(1);
    chk("R4 all clear", {2'b0, stat_q}, 8'h00);
    chk("R5 irq drops after slt clear", {7'b0, irq_o}, 8'h00);

    // R4: writing zeros has no effect
    pulse(5'b01000);
    chk("R2 arb set", {2'b0, stat_q}, 8'b0010_0100);
    write_stat(6'b000000);
    chk("R4 zero write ignored", {2'b0, stat_q}, 8'b0010_0100);

    // R9: set wins over clear in one cycle
    stat_we = 1'b1; stat_wdata = 6'b000100; ev_arb_lost = 1'b1;
    @(negedge clk);
    stat_we = 1'b0; stat_wdata = '0; ev_arb_lost = 1'b0;
    chk("R9 arb kept on collision", {2'b0, stat_q}, 8'b0010_0100);
    write_stat(6'b000100);
    chk("R4 arb cleared", {2'b0, stat_q}, 8'b0010_0000);

    // R8: live copy falls with the level, summary stays
    xfer_done = 1'b1;
    nclk(1);
    chk("R8 live copy high", {2'b0, stat_q}, 8'b0010_0001);
    xfer_done = 1'b0;
    nclk(1);
    chk("R8 live copy low", {2'b0, stat_q}, 8'b0010_0000);

    // R10: master off with flags already clear
    write_stat(6'b111110);
    write_ctrl(4'b1110);
    pulse(5'b11111);
    nclk(1);
    chk("R10 no flags when master off", {2'b0, stat_q}, 8'h00);
    chk("R10 no irq when master off", {7'b0, irq_o}, 8'h00);

    // R1: reset mid-run clears set state
    write_ctrl(4'b0011);
    pulse(5'b01100);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 stat cleared by reset", {2'b0, stat_q}, 8'h00);
    chk("R1 ctrl cleared by reset", {4'b0, ctrl_q}, 8'h00);
    chk("R1 irq cleared by reset", {7'b0, irq_o}, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule